// File: doc/BRIEF.md
# Instruction-Count Fetch Thread Selector

This block sits in the front end of a simultaneous-multithreading core. Each cycle it picks at most one of `NTHR` hardware threads to fetch. The pick favours the thread that currently holds the fewest instructions in the shared execution window. The window is the reorder buffer and issue queue taken together. To know those holdings, the block keeps a live count of in-flight instructions per thread. A count grows by the number of instructions the thread fetched and shrinks by the number it retired or had squashed, all applied in a single cycle.

A mode input sets how the window is shared.

- **Static partitioning:** each thread may hold at most `WIN/NTHR` entries. Once a thread's share is full it stops being a candidate.
- **Dynamic partitioning:** threads compete for the whole window with no per-thread cap. A thread that hoards entries can starve the others.

In both modes, fetch stops for every thread once the combined occupancy reaches the window size. When several candidates tie on the smallest count, a rotating pointer settles the tie.

Top module: `icf_fetch_select`

## Requirements
- R1: `fetch_grant` is one-hot or all zero in every cycle.
- R2: The grant goes to the eligible thread with the smallest in-flight count. It is derived combinationally from the current counts and inputs, within the same cycle.
- R3: At each rising clock edge, every thread's count becomes count + fetched − retired − squashed. Thread i's amounts sit in bits [i*FW +: FW] of `fetched_cnt`, `retired_cnt` and `squashed_cnt`, with FW = clog2(FETCH_MAX+1).
- R4: When retired plus squashed exceed count plus fetched, the count becomes zero rather than wrapping. A count also never wraps above its maximum representable value.
- R5: Only a thread whose `fetch_ready` bit is 1 can be granted. When no thread is eligible, the grant is all zero.
- R6: With `part_static` = 1, a thread whose count is at least WIN/NTHR is not eligible.
- R7: With `part_static` = 0, there is no per-thread limit. A ready thread can be granted whatever its own count, as long as R8 allows.
- R8: When the sum of all counts is at least WIN, no thread is granted.
- R9: Ties on the minimum count go to the first tied thread in the order that starts just after the last granted thread and wraps around. The pointer moves only in cycles with a grant. After reset the order starts at thread 0.
- R10: Reset clears every count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| part_static | input | 1 | 1 = static per-thread partitions, 0 = dynamic sharing |
| fetch_ready | input | NTHR | Bit i: thread i is ready to fetch |
| fetched_cnt | input | NTHR*FW | Instructions fetched per thread this cycle |
| retired_cnt | input | NTHR*FW | Instructions retired per thread this cycle |
| squashed_cnt | input | NTHR*FW | Instructions squashed per thread this cycle |
| fetch_grant | output | NTHR | One-hot fetch grant, or zero |

## Verification
The grant is combinational, so it answers the ready and mode inputs of the same cycle. The bench drives inputs on the falling edge and compares the grant one time unit later, well before the next rising edge.

Counter and pointer changes land at the next rising edge, one cycle after the fetched, retired and squashed amounts are presented. The bench folds those amounts into its own model only after that cycle's comparison. Its expected grant therefore always matches the state the design holds at the time of sampling.

// File: rtl/icf_pkg.sv
package icf_pkg;

  typedef enum logic {
    PART_DYNAMIC = 1'b0,
    PART_STATIC  = 1'b1
  } part_mode_e;

  // Count update with clamping at both ends.
  function automatic int unsigned icf_next_count(
    input int unsigned cur,
    input int unsigned add,
    input int unsigned sub,
    input int unsigned maxv
  );
    int unsigned up;
    up = cur + add;
    if (sub > up)            return 0;
    else if (up - sub > maxv) return maxv;
    else                     return up - sub;
  endfunction

endpackage

// File: rtl/icf_inflight_ctr.sv
module icf_inflight_ctr #(
  parameter int CNTW = 6,
  parameter int FW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FW-1:0]   add_i,
  input  logic [FW-1:0]   ret_i,
  input  logic [FW-1:0]   sq_i,
  output logic [CNTW-1:0] count_o
);
  import icf_pkg::*;

  localparam int unsigned MAXC = (1 << CNTW) - 1;

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            upd_en;

  always_comb begin
    upd_en = (add_i != '0) || (ret_i != '0) || (sq_i != '0);
    cnt_d  = CNTW'(icf_next_count(int'(cnt_q), int'(add_i),
                                  int'(ret_i) + int'(sq_i), MAXC));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (upd_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  // R4: removals beyond the held amount leave zero
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(cnt_q) + int'(add_i)) < (int'(ret_i) + int'(sq_i))) |=> (cnt_q == '0));

  // R3: in-range update lands exactly one edge later
  a_r3_update: assert property (@(posedge clk) disable iff (!rst_n)
    (((int'(cnt_q) + int'(add_i)) >= (int'(ret_i) + int'(sq_i))) &&
     ((int'(cnt_q) + int'(add_i) - int'(ret_i) - int'(sq_i)) <= int'(MAXC)))
    |=> (int'(cnt_q) == $past(int'(cnt_q) + int'(add_i) - int'(ret_i) - int'(sq_i))));

endmodule

// File: rtl/icf_eligibility.sv
module icf_eligibility #(
  parameter int NTHR = 4,
  parameter int CNTW = 6,
  parameter int WIN  = 32,
  parameter int TW   = 8
) (
  input  logic [NTHR-1:0]      ready_i,
  input  logic                 static_i,
  input  logic [NTHR*CNTW-1:0] counts_i,
  output logic [NTHR-1:0]      elig_o,
  output logic [TW-1:0]        total_o
);
  import icf_pkg::*;

  localparam int QUOTA = WIN / NTHR;

  part_mode_e      mode;
  logic            room;
  logic [NTHR-1:0] under_quota;

  always_comb begin
    mode    = part_mode_e'(static_i);
    total_o = '0;
    for (int i = 0; i < NTHR; i++)
      total_o = total_o + TW'(counts_i[i*CNTW +: CNTW]);
    room = (int'(total_o) < WIN);
  end

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    always_comb begin
      under_quota[g] = (int'(counts_i[g*CNTW +: CNTW]) < QUOTA);
      elig_o[g]      = ready_i[g] && room &&
                       ((mode == PART_DYNAMIC) || under_quota[g]);
    end
  end

endmodule

// File: rtl/icf_min_arbiter.sv
module icf_min_arbiter #(
  parameter int NTHR = 4,
  parameter int CNTW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NTHR-1:0]      elig_i,
  input  logic [NTHR*CNTW-1:0] counts_i,
  output logic [NTHR-1:0]      grant_o
);
  localparam int IW = (NTHR > 1) ? $clog2(NTHR) : 1;

  logic [IW-1:0]   ptr_q, ptr_d;
  logic [IW-1:0]   win_idx;
  logic [CNTW-1:0] win_cnt;
  logic            found;

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_cnt = '0;
    for (int k = 0; k < NTHR; k++) begin
      int idx;
      idx = (int'(ptr_q) + 1 + k) % NTHR;
      if (elig_i[idx] && (!found || counts_i[idx*CNTW +: CNTW] < win_cnt)) begin
        found   = 1'b1;
        win_idx = IW'(idx);
        win_cnt = counts_i[idx*CNTW +: CNTW];
      end
    end
    grant_o = '0;
    if (found) grant_o[win_idx] = 1'b1;
    ptr_d = win_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= IW'(NTHR - 1);
    else if (found) ptr_q <= ptr_d;
  end

  // R2: the winner never holds more than any other candidate
  for (genvar a = 0; a < NTHR; a++) begin : g_min_a
    for (genvar b = 0; b < NTHR; b++) begin : g_min_b
      if (a != b) begin : g_pair
        a_r2_min_count: assert property (@(posedge clk) disable iff (!rst_n)
          (grant_o[a] && elig_i[b]) |->
          (counts_i[a*CNTW +: CNTW] <= counts_i[b*CNTW +: CNTW]));
      end
    end
  end

  // R5: any candidate produces a grant
  a_r5_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_i != '0) |-> (grant_o != '0));

endmodule

// File: rtl/icf_fetch_select.sv
module icf_fetch_select #(
  parameter int NTHR      = 4,
  parameter int WIN       = 32,
  parameter int FETCH_MAX = 4,
  localparam int FW       = $clog2(FETCH_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                part_static,
  input  logic [NTHR-1:0]     fetch_ready,
  input  logic [NTHR*FW-1:0]  fetched_cnt,
  input  logic [NTHR*FW-1:0]  retired_cnt,
  input  logic [NTHR*FW-1:0]  squashed_cnt,
  output logic [NTHR-1:0]     fetch_grant
);
  localparam int CNTW  = $clog2(WIN + FETCH_MAX + 1);
  localparam int TW    = $clog2(NTHR * ((1 << CNTW) - 1) + 1);
  localparam int QUOTA = WIN / NTHR;

  logic [NTHR*CNTW-1:0] counts;
  logic [NTHR-1:0]      elig;
  logic [TW-1:0]        total;

  for (genvar g = 0; g < NTHR; g++) begin : g_ctr
    icf_inflight_ctr #(.CNTW(CNTW), .FW(FW)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .add_i   (fetched_cnt[g*FW +: FW]),
      .ret_i   (retired_cnt[g*FW +: FW]),
      .sq_i    (squashed_cnt[g*FW +: FW]),
      .count_o (counts[g*CNTW +: CNTW])
    );
  end

  icf_eligibility #(.NTHR(NTHR), .CNTW(CNTW), .WIN(WIN), .TW(TW)) u_elig (
    .ready_i  (fetch_ready),
    .static_i (part_static),
    .counts_i (counts),
    .elig_o   (elig),
    .total_o  (total)
  );

  icf_min_arbiter #(.NTHR(NTHR), .CNTW(CNTW)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .elig_i   (elig),
    .counts_i (counts),
    .grant_o  (fetch_grant)
  );

  // R1: at most one thread fetches
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fetch_grant));

  // R5: a grant is always backed by readiness
  a_r5_ready_only: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_grant & ~fetch_ready) == '0);

  // R8: a full window blocks all fetch
  a_r8_full_window: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(total) >= WIN) |-> (fetch_grant == '0));

  // R6: static partitions are never exceeded by a grant
  for (genvar g = 0; g < NTHR; g++) begin : g_chk
    a_r6_static_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (part_static && fetch_grant[g]) |-> (int'(counts[g*CNTW +: CNTW]) < QUOTA));
  end

endmodule

// File: tb/icf_fetch_select_test.sv
module icf_fetch_select_test;
  localparam int NTHR = 4;
  localparam int WIN = 32;
  localparam int FETCH_MAX = 4;
  localparam int FW = $clog2(FETCH_MAX + 1);
  localparam int CNTW = $clog2(WIN + FETCH_MAX + 1);
  localparam int MAXC = (1 << CNTW) - 1;
  localparam int QUOTA = WIN / NTHR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic part_static = 1'b0;
  logic [NTHR-1:0] fetch_ready = '0;
  logic [NTHR*FW-1:0] fetched_cnt = '0, retired_cnt = '0, squashed_cnt = '0;
  logic [NTHR-1:0] fetch_grant;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  int m_cnt [NTHR];
  int m_ptr;

  always #2 clk = ~clk;  // 250 MHz

  icf_fetch_select #(.NTHR(NTHR), .WIN(WIN), .FETCH_MAX(FETCH_MAX)) uut (
    .clk(clk), .rst_n(rst_n), .part_static(part_static),
    .fetch_ready(fetch_ready), .fetched_cnt(fetched_cnt),
    .retired_cnt(retired_cnt), .squashed_cnt(squashed_cnt),
    .fetch_grant(fetch_grant));

  function automatic int exp_winner(input logic [NTHR-1:0] rdy, input logic md);
    int total, best;
    total = 0; best = -1;
    for (int i = 0; i < NTHR; i++) total += m_cnt[i];
    for (int k = 0; k < NTHR; k++) begin
      int idx;
      idx = (m_ptr + 1 + k) % NTHR;
      if (rdy[idx] && total < WIN && (!md || m_cnt[idx] < QUOTA))
        if (best < 0 || m_cnt[idx] < m_cnt[best]) best = idx;
    end
    return best;
  endfunction

  task automatic check(input string tag, input logic [NTHR-1:0] got, input logic [NTHR-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: grant=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic step(input logic [NTHR-1:0] rdy, input logic md,
                      input logic [NTHR*FW-1:0] ret, input logic [NTHR*FW-1:0] sq,
                      input int famt, input string tag);
    int w;
    logic [NTHR-1:0] e;
    @(negedge clk);
    fetch_ready = rdy; part_static = md; retired_cnt = ret; squashed_cnt = sq;
    w = exp_winner(rdy, md);
    e = '0;
    fetched_cnt = '0;
    if (w >= 0) begin
      e[w] = 1'b1;
      fetched_cnt[w*FW +: FW] = FW'(famt);
    end
    #1;
    check(tag, fetch_grant, e);
    if (w >= 0) m_ptr = w;
    for (int i = 0; i < NTHR; i++) begin
      int up, dn;
      up = m_cnt[i] + int'(fetched_cnt[i*FW +: FW]);
      dn = int'(ret[i*FW +: FW]) + int'(sq[i*FW +: FW]);
      m_cnt[i] = (dn > up) ? 0 : ((up - dn > MAXC) ? MAXC : up - dn);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: cycles=%0d expected<=%0d", cyc, 200000);
        finish_run();
      end
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    for (int i = 0; i < NTHR; i++) m_cnt[i] = 0;
    m_ptr = NTHR - 1;
    #1;
    check("R10 reset grant", fetch_grant, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 / R9: counts zero, thread 0 first
    step(4'b1111, 1'b1, '0, '0, 4, "R10 first grant");
    step(4'b1111, 1'b1, '0, '0, 4, "R9 tie rotation");
    step(4'b1111, 1'b1, '0, '0, 4, "R9 tie rotation");
    step(4'b1111, 1'b1, '0, '0, 4, "R9 tie rotation");
    step(4'b1111, 1'b1, '0, '0, 4, "R2 min among equals");
    // R5: nobody ready
    step(4'b0000, 1'b1, '0, '0, 0, "R5 no ready");
    // R6: thread 0 at quota in static mode
    step(4'b0001, 1'b1, '0, '0, 0, "R6 static cap");
    // R7: same thread allowed in dynamic mode
    step(4'b0001, 1'b0, '0, '0, 4, "R7 dynamic no cap");
    step(4'b0001, 1'b0, '0, '0, 0, "R7 dynamic above quota");
    // R4: removals exceed holdings on thread 0
    step(4'b0000, 1'b0, {3'd0, 3'd0, 3'd0, 3'd4}, {3'd0, 3'd0, 3'd0, 3'd4}, 0, "R4 clamp setup");
    step(4'b0000, 1'b0, {3'd0, 3'd0, 3'd0, 3'd4}, {3'd0, 3'd0, 3'd0, 3'd4}, 0, "R4 clamp");
    step(4'b1111, 1'b0, '0, '0, 0, "R4 cleared thread wins");
    // R8: fill window in dynamic mode
    for (int k = 0; k < 10; k++) step(4'b0010, 1'b0, '0, '0, 4, "R8 fill");
    step(4'b1111, 1'b0, '0, '0, 0, "R8 full window");
    step(4'b1111, 1'b1, '0, '0, 0, "R8 full static");
    // random traffic, R2 / R3 / R1
    for (int n = 0; n < 3000; n++) begin
      logic [NTHR*FW-1:0] r, s;
      r = '0; s = '0;
      for (int i = 0; i < NTHR; i++) begin
        int lim;
        lim = (m_cnt[i] > FETCH_MAX) ? FETCH_MAX : m_cnt[i];
        if ($urandom_range(9) == 0) lim = FETCH_MAX;
        r[i*FW +: FW] = FW'($urandom_range(lim));
        if ($urandom_range(15) == 0) s[i*FW +: FW] = FW'($urandom_range(FETCH_MAX));
      end
      step(NTHR'($urandom), 1'($urandom_range(1)), r, s,
           $urandom_range(FETCH_MAX), "R2 R3 random");
    end
    finish_run();
  end
endmodule